// File: doc/BRIEF.md
# Buffered SPI Master Transfer Engine

This block is a master-side serial peripheral interface engine for 8-bit frames. It derives the serial clock from the system clock through a programmable divider. It drives one of several active-low chip-select lines. It moves data through three registers: a transmit holding register, one shift register that serves both directions, and a receive holding register.

Software or a DMA channel writes a byte into the transmit holding register. If the engine is enabled and idle, the byte is moved into the shift register and a frame starts. A byte written while a frame is running waits in the holding register. It is loaded at the last clock edge of the running frame, so the next frame follows with no gap and chip-select stays asserted. Every frame clocks the shift register out on MOSI and fills the same register from MISO. The received byte is then copied to the receive holding register. Status flags report whether the transmit holding register is empty, whether a received byte is waiting, and whether a received byte was lost.

Clock polarity, clock phase and slave index are taken when a frame is loaded from idle. Back-to-back frames keep the values of the first frame.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, all chip-select lines are high, `sck_o` equals `cpol_i`, `mosi_o` is 0, `tx_empty_o` is 1, and both `rx_full_o` and `overrun_o` are 0.
- R2: When a byte is loaded from idle, only line `cs_sel_i` of `cs_no_o` goes low (bit i low selects slave i). It goes low on the same clock edge as the load, and no other line is ever low at the same time.
- R3: With D = `div_i` (a value of 0 acts as 1), SCK changes every D clock cycles. Counting from the load edge, the first SCK edge comes 2·D cycles later. The 16th edge, which ends the frame, comes 17·D cycles later. With no frame running, SCK sits at `cpol_i`.
- R4: Frames are 8 bits, MSB first on MOSI. The byte taken in from MISO, MSB first, appears on `rx_data_o` when the frame ends.
- R5: With `cpha_i` = 0, MOSI changes on leading SCK edges and MISO is sampled on trailing edges. Before the first edge, MOSI keeps its previous level, which is the last bit of the previous frame. With `cpha_i` = 1, MOSI shows the MSB from the load edge onward, MISO is sampled on leading edges, and MOSI changes on trailing edges.
- R6: A byte written during a frame stays queued until that frame's last edge and is loaded on that edge. The next frame's first edge follows D cycles later, so frame ends are 16·D cycles apart, and chip-select stays low in between.
- R7: `tx_empty_o` goes low on the clock edge after a write to the transmit holding register. It goes high on the edge where that byte moves into the shift register.
- R8: `rx_full_o` goes high when a frame ends and goes low on the edge after a `rx_rd_i` pulse. If a read and a new byte arrive in the same cycle, the flag stays high.
- R9: `overrun_o` goes high when a frame ends while `rx_full_o` is still high and there is no read in that cycle. `rx_data_o` then holds the newest byte. A `rx_rd_i` pulse clears `overrun_o`.
- R10: When no byte is queued, chip-select goes back high D cycles after the frame's last edge, which is 18·D cycles after the load edge.
- R11: While `en_i` is 0, a written byte stays in the holding register and no frame starts. The frame starts on the first edge where `en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows new frames to start |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | Sampling phase select |
| div_i | input | DIV_W | Half-period length of SCK in clock cycles |
| cs_sel_i | input | CS_W | Index of the slave to select |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | DATA_W | Byte to transmit |
| rx_rd_i | input | 1 | Read strobe for the receive holding register |
| rx_data_o | output | DATA_W | Last byte received |
| tx_empty_o | output | 1 | Transmit holding register empty (DMA request) |
| rx_full_o | output | 1 | Received byte waiting |
| overrun_o | output | 1 | A received byte was overwritten before it was read |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| cs_no | output | NUM_CS | Chip-select lines, active low |

## Verification
All timing is counted from the load edge, which is the clock edge after the write strobe:
- `tx_empty_o` is low one cycle after the write and high again two cycles after it.
- Chip-select falls on the load edge.
- The first SCK edge comes 2·D cycles after the load edge, and the received byte with `rx_full_o` comes 17·D cycles after it.
- Chip-select rises 18·D cycles after the load edge.
- A queued frame ends exactly 16·D cycles after the one before it.

The bench drives inputs on falling clock edges, samples on falling edges, and counts cycles from the write strobe. Each count is compared with the exact formula, not a range. A model slave on the bench shifts a known byte onto MISO and records MOSI. This checks bit order and phase in both directions.

// File: rtl/spi_buf_pkg.sv
`timescale 1ns/1ps
package spi_buf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL
  } eng_state_e;
endpackage

// File: rtl/spi_baud_div.sv
`timescale 1ns/1ps
module spi_baud_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a divider of 0 behaves as 1
  assign lim    = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core
  import spi_buf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [CS_W-1:0]   cs_sel_i,
  input  logic              tick_i,
  input  logic              hold_valid_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              miso_i,
  output logic              load_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              run_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [NUM_CS-1:0] cs_no
);
  localparam int unsigned EDGES     = 2 * DATA_W;
  localparam int unsigned EDGE_W    = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  eng_state_e        state_q;
  logic [DATA_W-1:0] sr_q;
  logic [EDGE_W-1:0] edge_q;
  logic              sck_q, mosi_q, cpol_q, cpha_q;
  logic [CS_W-1:0]   cs_idx_q;

  logic in_xfer, capture, change, last, start_idle, chain;

  assign in_xfer    = (state_q == ST_XFER);
  // even edges lead; phase 0 samples on odd edges, phase 1 on even edges
  assign capture    = tick_i && in_xfer && (edge_q[0] != cpha_q);
  assign change     = tick_i && in_xfer && (edge_q[0] == cpha_q);
  assign last       = tick_i && in_xfer && (edge_q == LAST_EDGE);
  assign start_idle = (state_q == ST_IDLE) && en_i && hold_valid_i;
  assign chain      = last && en_i && hold_valid_i;

  assign load_o    = start_idle || chain;
  assign done_o    = last;
  assign rx_word_o = cpha_q ? sr_q : {sr_q[DATA_W-2:0], miso_i};
  assign run_o     = (state_q != ST_IDLE);
  assign sck_o     = (state_q == ST_IDLE) ? cpol_i : sck_q;
  assign mosi_o    = mosi_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_no[i] = !(run_o && (cs_idx_q == CS_W'(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sr_q     <= '0;
      edge_q   <= '0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      cs_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_idle) begin
            sr_q     <= hold_data_i;
            cpol_q   <= cpol_i;
            cpha_q   <= cpha_i;
            cs_idx_q <= cs_sel_i;
            sck_q    <= cpol_i;
            edge_q   <= '0;
            if (cpha_i) mosi_q <= hold_data_i[DATA_W-1];
            state_q  <= ST_LEAD;
          end
        end
        ST_LEAD: if (tick_i) state_q <= ST_XFER;
        ST_XFER: begin
          if (tick_i) begin
            sck_q  <= ~sck_q;
            edge_q <= edge_q + 1'b1;
            if (capture) sr_q <= {sr_q[DATA_W-2:0], miso_i};
            if (change && !(cpha_q && last)) mosi_q <= sr_q[DATA_W-1];
            if (last) begin
              edge_q <= '0;
              if (chain) begin
                sr_q <= hold_data_i;
                if (cpha_q) mosi_q <= hold_data_i[DATA_W-1];
              end else begin
                state_q <= ST_TRAIL;
              end
            end
          end
        end
        ST_TRAIL: if (tick_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_cpol;
  assign unused_cpol = cpol_q;
endmodule

// File: rtl/spi_rx_hold.sv
`timescale 1ns/1ps
module spi_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (done_i) data_o <= word_i;
      full_o <= done_i || (full_o && !rd_i);
      ovr_o  <= (ovr_o && !rd_i) || (done_i && full_o && !rd_i);
    end
  end
endmodule

// File: rtl/spi_buf_master.sv
`timescale 1ns/1ps
module spi_buf_master #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CS_W-1:0]   cs_sel_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no
);
  logic [DATA_W-1:0] thr_q;
  logic              load, done, run, tick;
  logic [DATA_W-1:0] rx_word;

  // a write in the load cycle wins the flag; the load takes the old byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q      <= '0;
      tx_empty_o <= 1'b1;
    end else if (tx_wr_i) begin
      thr_q      <= tx_data_i;
      tx_empty_o <= 1'b0;
    end else if (load) begin
      tx_empty_o <= 1'b1;
    end
  end

  spi_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .tick_o (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cpol_i       (cpol_i),
    .cpha_i       (cpha_i),
    .cs_sel_i     (cs_sel_i),
    .tick_i       (tick),
    .hold_valid_i (!tx_empty_o),
    .hold_data_i  (thr_q),
    .miso_i       (miso_i),
    .load_o       (load),
    .done_o       (done),
    .rx_word_o    (rx_word),
    .run_o        (run),
    .sck_o        (sck_o),
    .mosi_o       (mosi_o),
    .cs_no        (cs_no)
  );

  spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .word_i (rx_word),
    .rd_i   (rx_rd_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .ovr_o  (overrun_o)
  );
endmodule

// File: rtl/spi_buf_master_chk.sv
`timescale 1ns/1ps
module spi_buf_master_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              cpol_i,
  input logic              tx_wr_i,
  input logic              rx_rd_i,
  input logic              tx_empty_o,
  input logic              rx_full_o,
  input logic              overrun_o,
  input logic              sck_o,
  input logic [NUM_CS-1:0] cs_no
);
  p_cs_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> (sck_o == cpol_i));

  p_tx_empty_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(tx_wr_i));

  p_rx_full_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> !$past(&cs_no));

  p_rx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && rx_rd_i && (&cs_no)) |=> !rx_full_o);

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_full_o));

  p_start_en_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(&cs_no) |-> $past(en_i));
endmodule

bind spi_buf_master spi_buf_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cpol_i     (cpol_i),
  .tx_wr_i    (tx_wr_i),
  .rx_rd_i    (rx_rd_i),
  .tx_empty_o (tx_empty_o),
  .rx_full_o  (rx_full_o),
  .overrun_o  (overrun_o),
  .sck_o      (sck_o),
  .cs_no      (cs_no)
);

// File: tb/spi_buf_master_tb.sv
`timescale 1ns/1ps
module spi_buf_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] div = 8'd1;
  logic [1:0] csel = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rx_data;
  logic       tx_empty, rx_full, ovr, sck, mosi;
  logic       miso = 1'b0;
  logic [3:0] cs_n;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_buf_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .div_i(div), .cs_sel_i(csel), .tx_wr_i(wr), .tx_data_i(wdata),
    .rx_rd_i(rd), .rx_data_o(rx_data), .tx_empty_o(tx_empty),
    .rx_full_o(rx_full), .overrun_o(ovr), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n)
  );

  // model slave: MISO byte per frame, MOSI recorded per frame
  logic [7:0] sb [2];
  logic [7:0] srx [2];
  logic [7:0] sh = '0;
  int fi = 0, ec = 0;

  always @(sck) begin
    if (!(&cs_n)) begin
      if (ec % 2 == 0) begin
        if (!cpha) miso = sb[fi % 2][7 - ec / 2];
        else       sh = {sh[6:0], mosi};
      end else begin
        if (!cpha) sh = {sh[6:0], mosi};
        else if (ec != 15) miso = sb[fi % 2][7 - (ec + 1) / 2];
      end
      if (ec == 15) begin
        srx[fi % 2] = sh;
        fi = fi + 1;
        if (cpha) miso = sb[fi % 2][7];
        ec = 0;
      end else begin
        ec = ec + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep(input logic p, input logic h, input logic [7:0] d,
                      input logic [1:0] c, input logic [7:0] s0, input logic [7:0] s1);
    @(negedge clk);
    cpol = p; cpha = h; div = d; csel = c;
    sb[0] = s0; sb[1] = s1; fi = 0; ec = 0;
    if (h) miso = s0[7];
  endtask

  task automatic write(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // cpol, cpha, div, cs, tx, slave byte
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 8'd2, 2'd0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'd3, 2'd1, 8'h5A, 8'hC3},
    {1'b0, 1'b1, 8'd1, 2'd2, 8'h81, 8'h7E},
    {1'b1, 1'b1, 8'd4, 2'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'd0, 2'd1, 8'h6B, 8'hD4},
    {1'b1, 1'b1, 8'd2, 2'd0, 8'hC6, 8'h39}
  };

  initial begin
    #(150000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic prev_lsb;
    int n, de, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cs_n == 4'hF, "R1 cs", cs_n, 4'hF);
    chk(sck == cpol, "R1 sck", sck, cpol);
    chk(mosi == 1'b0, "R1 mosi", mosi, 0);
    chk(tx_empty && !rx_full && !ovr, "R1 flags", {tx_empty, rx_full, ovr}, 3'b100);

    prev_lsb = 1'b0;
    for (int i = 0; i < 6; i++) begin
      logic [27:0] v;
      v = VEC[i];
      de = (v[25:18] == 0) ? 1 : int'(v[25:18]);
      prep(v[27], v[26], v[25:18], v[17:16], v[7:0], 8'h00);
      write(v[15:8]);
      chk(!tx_empty, "R7 clear", tx_empty, 0);
      @(negedge clk);
      chk(tx_empty, "R7 set on load", tx_empty, 1);
      chk(cs_n == ~(4'b1 << v[17:16]), "R2 select", cs_n, ~(4'b1 << v[17:16]));
      if (v[26]) chk(mosi == v[15], "R5 cpha1 msb early", mosi, v[15]);
      else       chk(mosi == prev_lsb, "R5 cpha0 prev lsb", mosi, prev_lsb);
      n = 2;
      while (sck == v[27] && n < 300) begin @(negedge clk); n++; end
      chk(n == 2 + 2 * de, "R3 first edge", n, 2 + 2 * de);
      while (!rx_full && n < 1000) begin @(negedge clk); n++; end
      chk(n == 2 + 17 * de, "R3 frame end", n, 2 + 17 * de);
      chk(rx_data == v[7:0], "R4 rx byte", rx_data, v[7:0]);
      chk(srx[0] == v[15:8], "R4 mosi byte", srx[0], v[15:8]);
      while (cs_n != 4'hF && n < 1000) begin @(negedge clk); n++; end
      chk(n == 2 + 18 * de, "R10 release", n, 2 + 18 * de);
      chk(sck == v[27], "R3 idle level", sck, v[27]);
      rd_pulse();
      chk(!rx_full, "R8 read clears", rx_full, 0);
      prev_lsb = v[8];
    end

    // back to back with overrun: R6 R7 R9
    prep(1'b0, 1'b0, 8'd2, 2'd2, 8'h96, 8'hE1);
    write(8'h3C);
    @(negedge clk);
    repeat (4) @(negedge clk);
    write(8'h99);
    repeat (3) @(negedge clk);
    chk(!tx_empty, "R6 queued held", tx_empty, 0);
    n = 0;
    while (!rx_full && n < 1000) begin @(negedge clk); n++; end
    chk(tx_empty, "R7 set at chain load", tx_empty, 1);
    chk(cs_n == 4'b1011, "R6 cs held", cs_n, 4'b1011);
    chk(!ovr, "R9 no overrun yet", ovr, 0);
    t0 = n;
    while (!ovr && n < 2000) begin @(negedge clk); n++; end
    chk(n - t0 == 32, "R6 spacing", n - t0, 32);
    chk(ovr, "R9 overrun set", ovr, 1);
    chk(rx_data == 8'hE1, "R9 newest byte", rx_data, 8'hE1);
    chk(srx[0] == 8'h3C && srx[1] == 8'h99, "R6 mosi bytes", {srx[0], srx[1]}, 16'h3C99);
    while (cs_n != 4'hF && n < 3000) begin @(negedge clk); n++; end
    rd_pulse();
    chk(!rx_full && !ovr, "R8 R9 read clears", {rx_full, ovr}, 0);

    // enable gating: R11
    prep(1'b0, 1'b1, 8'd1, 2'd3, 8'hB2, 8'h00);
    en = 1'b0;
    write(8'h55);
    repeat (10) @(negedge clk);
    chk(cs_n == 4'hF && !tx_empty, "R11 held off", {cs_n, tx_empty}, 5'b11110);
    en = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'b0111, "R11 start", cs_n, 4'b0111);
    n = 0;
    while (!rx_full && n < 1000) begin @(negedge clk); n++; end
    chk(rx_data == 8'hB2 && srx[0] == 8'h55, "R11 frame", {rx_data, srx[0]}, 16'hB255);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule